// File: doc/BRIEF.md
# Transmit Frame Packer

This block takes the bytes of one outgoing Ethernet frame from a valid/ready byte stream and stores them into a packet buffer as 16-bit words, in the layout the transmit engine reads. Each frame in the buffer begins with two header words: a status word that is cleared to zero, and a byte-count word. The payload follows, two bytes per word. A control word closes the frame and tells the transmitter whether the final payload byte stands alone. Frames shorter than the Ethernet minimum of 60 bytes (FCS not included) are padded with zero bytes up to that length.

The frame length is not known until the last byte arrives, so the packer writes the byte-count word last, after the control word. It marks that final write with a one-cycle done pulse, and the pulse carries the number of words the frame occupies. A buffer allocator hands over a region whose word addresses start at zero. The consumer starts transmission on the done pulse. One frame is handled at a time. The next frame's status word goes to address zero again.

Top module: `tx_frame_packer`

## Requirements
- R1: While reset is held and in the first cycle after it, the write strobe, the done pulse and the input ready are all low.
- R2: A frame begins when input valid is seen. The packer writes 0x0000 to word address 0 before it accepts any byte, and input ready first rises in the same cycle as that write.
- R3: Payload byte i is placed at word address 2 + i/2. An even i goes in bits 7:0 and an odd i goes in bits 15:8.
- R4: If the frame has fewer than 60 bytes, it is extended with zero bytes up to 60. The padded length L is used for every later word.
- R5: Word address 1 receives L + 6. This is the last write of the frame and happens in the same cycle as the done pulse.
- R6: If L is even, the control word at address 2 + L/2 is 0x0000. It is written in the cycle just before the byte-count word.
- R7: If L is odd, the control word at address 2 + (L-1)/2 holds the last byte in bits 7:0 and has bit 13 set (0x2000), with all other bits zero.
- R8: Every address from 0 to L/2 + 2 (integer division) is written exactly once per frame, and no other address is written.
- R9: The done pulse lasts one cycle. Its word-count output equals L/2 + 3 (integer division).
- R10: Cycles in which input valid is low change neither the buffer contents nor the byte order.
- R11: Input ready is low from the cycle after the last byte is accepted until the done pulse has finished. The next frame starts again at address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Byte on in_data is valid |
| in_data | input | 8 | Frame byte |
| in_last | input | 1 | Marks the final byte of the frame |
| in_ready | output | 1 | Packer accepts the byte this cycle |
| wr_en | output | 1 | Buffer word write strobe |
| wr_addr | output | ADDR_W (10) | Word address within the frame region |
| wr_data | output | 16 | Word to store |
| done | output | 1 | One-cycle pulse on the final write of a frame |
| done_words | output | ADDR_W (10) | Words occupied by the frame, valid with done |

## Verification
If the byte counter goes wrong, the error shows at the ports in three places. The byte-count word is off, the control word lands at the wrong address, and done_words no longer matches. All three become visible only at the end of the frame. If the held low byte or the pad/tail phase goes wrong, a word comes out with its bytes swapped or with a stale byte in place of zero padding. This is visible on the very next write. If the phase machine goes wrong, addresses are skipped or written twice, or ready reopens early. Within one frame such an error shows as a wrong number of writes or as a done pulse not at address 1.

// File: rtl/tfp_pkg.sv
package tfp_pkg;

    // Ethernet minimum payload length without FCS; must be even.
    localparam int MIN_FRAME_BYTES = 60;
    // Bytes added by status word, count word and control word.
    localparam int HDR_TAIL_BYTES  = 6;
    // Flag in the control word marking a lone trailing byte.
    localparam logic [15:0] ODD_BYTE_FLAG = 16'h2000;

    typedef enum logic [2:0] {
        PH_HEAD,   // waiting for a frame, emits the status word
        PH_BODY,   // accepting payload bytes
        PH_PAD,    // appending zero bytes up to the minimum
        PH_TAIL,   // emitting the control word
        PH_COUNT   // emitting the byte-count word and done
    } phase_e;

    typedef struct packed {
        logic        en;
        logic [15:0] data;
    } word_wr_t;

    function automatic logic [15:0] pack_pair(input logic [7:0] lo, input logic [7:0] hi);
        return {hi, lo};
    endfunction

    function automatic logic [15:0] tail_word(input logic odd, input logic [7:0] last_byte);
        return odd ? (ODD_BYTE_FLAG | {8'h00, last_byte}) : 16'h0000;
    endfunction

endpackage

// File: rtl/tfp_byte_track.sv
module tfp_byte_track #(
    parameter int LEN_W     = 11,
    parameter int MAX_BYTES = 1514
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic [1:0]       step,
    input  logic             take,
    input  logic [7:0]       byte_in,
    output logic [LEN_W-1:0] cnt,
    output logic [7:0]       held
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            held <= '0;
        end else begin
            if (clr) cnt <= '0;
            else     cnt <= cnt + LEN_W'(step);
            if (take) held <= byte_in;
        end
    end

    // R4: padding never runs past the longest legal frame
    p_len_bound_r4: assert property (@(posedge clk) disable iff (rst)
        cnt <= LEN_W'(MAX_BYTES));

endmodule

// File: rtl/tfp_wr_reg.sv
module tfp_wr_reg
    import tfp_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  word_wr_t          nx_wr,
    input  logic [ADDR_W-1:0] nx_addr,
    input  logic              nx_done,
    input  logic [ADDR_W-1:0] nx_words,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [15:0]       wr_data,
    output logic              done,
    output logic [ADDR_W-1:0] done_words
);

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_en      <= 1'b0;
            wr_addr    <= '0;
            wr_data    <= '0;
            done       <= 1'b0;
            done_words <= '0;
        end else begin
            wr_en      <= nx_wr.en;
            wr_addr    <= nx_addr;
            wr_data    <= nx_wr.data;
            done       <= nx_done;
            done_words <= nx_words;
        end
    end

    // R9: the completion marker lasts exactly one cycle
    p_done_single_r9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

endmodule

// File: rtl/tx_frame_packer.sv
module tx_frame_packer
    import tfp_pkg::*;
#(
    parameter int MAX_BYTES = 1514,
    parameter int MIN_BYTES = MIN_FRAME_BYTES,
    localparam int LEN_W    = $clog2(MAX_BYTES + 1),
    localparam int ADDR_W   = $clog2(MAX_BYTES / 2 + 4)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [7:0]        in_data,
    input  logic              in_last,
    output logic              in_ready,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [15:0]       wr_data,
    output logic              done,
    output logic [ADDR_W-1:0] done_words
);

    phase_e            phase, phase_n;
    logic [LEN_W-1:0]  cnt;
    logic [7:0]        held;
    logic              clr, take;
    logic [1:0]        step;
    word_wr_t          nx_wr;
    logic [ADDR_W-1:0] nx_addr, nx_words, word_idx;
    logic              nx_done;
    logic [LEN_W:0]    cnt_after;

    assign word_idx  = ADDR_W'(cnt >> 1) + ADDR_W'(2);
    assign cnt_after = {1'b0, cnt} + (LEN_W+1)'(step);
    assign in_ready  = (phase == PH_BODY);

    always_ff @(posedge clk) begin
        if (rst) phase <= PH_HEAD;
        else     phase <= phase_n;
    end

    always_comb begin
        phase_n    = phase;
        clr        = 1'b0;
        take       = 1'b0;
        step       = 2'd0;
        nx_wr.en   = 1'b0;
        nx_wr.data = 16'h0000;
        nx_addr    = '0;
        nx_done    = 1'b0;
        nx_words   = '0;
        unique case (phase)
            PH_HEAD: begin
                if (in_valid) begin
                    nx_wr.en = 1'b1;
                    clr      = 1'b1;
                    phase_n  = PH_BODY;
                end
            end
            PH_BODY: begin
                if (in_valid) begin
                    step = 2'd1;
                    if (!cnt[0]) begin
                        take = 1'b1;
                    end else begin
                        nx_wr.en   = 1'b1;
                        nx_addr    = word_idx;
                        nx_wr.data = pack_pair(held, in_data);
                    end
                    if (in_last) begin
                        if (cnt_after < (LEN_W+1)'(MIN_BYTES)) phase_n = PH_PAD;
                        else                                   phase_n = PH_TAIL;
                    end
                end
            end
            PH_PAD: begin
                nx_wr.en = 1'b1;
                nx_addr  = word_idx;
                if (cnt[0]) begin
                    step       = 2'd1;
                    nx_wr.data = pack_pair(held, 8'h00);
                end else begin
                    step       = 2'd2;
                end
                if (cnt_after >= (LEN_W+1)'(MIN_BYTES)) phase_n = PH_TAIL;
            end
            PH_TAIL: begin
                nx_wr.en   = 1'b1;
                nx_addr    = word_idx;
                nx_wr.data = tail_word(cnt[0], held);
                phase_n    = PH_COUNT;
            end
            PH_COUNT: begin
                nx_wr.en   = 1'b1;
                nx_addr    = ADDR_W'(1);
                nx_wr.data = 16'(cnt) + 16'(HDR_TAIL_BYTES);
                nx_done    = 1'b1;
                nx_words   = word_idx + ADDR_W'(1);
                phase_n    = PH_HEAD;
            end
            default: phase_n = PH_HEAD;
        endcase
    end

    tfp_byte_track #(.LEN_W(LEN_W), .MAX_BYTES(MAX_BYTES)) u_track (
        .clk     (clk),
        .rst     (rst),
        .clr     (clr),
        .step    (step),
        .take    (take),
        .byte_in (in_data),
        .cnt     (cnt),
        .held    (held)
    );

    tfp_wr_reg #(.ADDR_W(ADDR_W)) u_wr (
        .clk        (clk),
        .rst        (rst),
        .nx_wr      (nx_wr),
        .nx_addr    (nx_addr),
        .nx_done    (nx_done),
        .nx_words   (nx_words),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .done       (done),
        .done_words (done_words)
    );

    // R2: payload acceptance opens together with the status-word write
    p_status_first_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(in_ready) |-> (wr_en && wr_addr == '0 && wr_data == 16'h0000));

    // R5: completion coincides with the count word at address 1
    p_done_on_count_r5: assert property (@(posedge clk) disable iff (rst)
        done |-> (wr_en && wr_addr == ADDR_W'(1)));

    // R6: the control word is written in the cycle before completion
    p_tail_before_count_r6: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(wr_en));

    // R11: no byte is accepted while a frame is being closed
    p_ready_closed_r11: assert property (@(posedge clk) disable iff (rst)
        done |-> !in_ready);

endmodule

// File: tb/tb_tx_frame_packer.sv
module tb_tx_frame_packer;

    localparam int AW = 10;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic [7:0]    in_data = 8'h00;
    logic          in_last = 1'b0;
    logic          in_ready;
    logic          wr_en;
    logic [AW-1:0] wr_addr;
    logic [15:0]   wr_data;
    logic          done;
    logic [AW-1:0] done_words;

    always #5 clk = ~clk;

    tx_frame_packer dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .in_last(in_last), .in_ready(in_ready), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .done(done),
        .done_words(done_words)
    );

    int   n_checks = 0;
    int   n_fails  = 0;
    bit   finished = 1'b0;

    logic [15:0] mem  [0:1023];
    int          hits [0:1023];
    int          n_writes;
    int          n_done;
    int          seen_words;
    int          done_addr_bad;
    int          ready_before_status;
    int          ready_after_last;
    bit          last_taken;
    logic [7:0]  pay [0:1599];

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0d (0x%0h) expected=%0d (0x%0h)", req, act, act, exp, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            if (wr_en) begin
                mem[wr_addr] = wr_data;
                hits[wr_addr]++;
                n_writes++;
            end
            if (in_ready && hits[0] == 0) ready_before_status++;
            if (in_ready && last_taken) ready_after_last++;
            if (done) begin
                n_done++;
                seen_words = int'(done_words);
                if (!(wr_en && wr_addr == AW'(1))) done_addr_bad++;
            end
        end
    end

    task automatic clear_log();
        for (int a = 0; a < 1024; a++) begin
            mem[a]  = 16'hxxxx;
            hits[a] = 0;
        end
        n_writes = 0; n_done = 0; seen_words = -1; done_addr_bad = 0;
        ready_before_status = 0; ready_after_last = 0; last_taken = 1'b0;
    endtask

    // Drives one frame of n bytes, then checks every word of its buffer image.
    task automatic run_frame(input int n, input int seed, input bit bubbles, input string tag);
        int L, words, idx, cyc, bad_payload, bad_hits, wait_cyc;
        logic [7:0] p_lo, p_hi, lastb;
        logic [15:0] exp_w;
        clear_log();
        for (int i = 0; i < n; i++) pay[i] = 8'((seed * 7 + i * 13 + (i >> 3)) & 255);
        idx = 0; cyc = 0;
        while (idx < n) begin
            @(negedge clk);
            cyc++;
            if (bubbles && (cyc % 3 == 1)) begin
                in_valid = 1'b0;
                in_data  = 8'hA5;
                in_last  = 1'b1;
            end else begin
                in_valid = 1'b1;
                in_data  = pay[idx];
                in_last  = (idx == n - 1);
                if (in_ready) begin
                    @(posedge clk);
                    if (idx == n - 1) last_taken = 1'b1;
                    idx++;
                end
            end
        end
        @(negedge clk);
        in_valid = 1'b0; in_last = 1'b0;
        wait_cyc = 0;
        while (n_done == 0 && wait_cyc < 200) begin
            @(negedge clk);
            wait_cyc++;
        end
        repeat (2) @(negedge clk);
        last_taken = 1'b0;

        L = (n < 60) ? 60 : n;
        words = L / 2 + 3;
        check(mem[0] === 16'h0000, {"R2 status word ", tag}, int'(mem[0]), 0);
        check(ready_before_status == 0, {"R2 ready before status ", tag}, ready_before_status, 0);
        check(mem[1] === 16'(L + 6), {"R5 count word ", tag}, int'(mem[1]), L + 6);
        bad_payload = 0;
        for (int k = 0; k < L / 2; k++) begin
            p_lo = (2*k < n) ? pay[2*k] : 8'h00;
            p_hi = (2*k+1 < n) ? pay[2*k+1] : 8'h00;
            if (mem[2+k] !== {p_hi, p_lo}) bad_payload++;
        end
        check(bad_payload == 0, {(n < 60) ? "R4 padded payload " : "R3 payload words ", tag},
              bad_payload, 0);
        lastb = (L - 1 < n) ? pay[L-1] : 8'h00;
        exp_w = (L % 2 == 1) ? (16'h2000 | {8'h00, lastb}) : 16'h0000;
        check(mem[2 + L/2] === exp_w, {(L % 2 == 1) ? "R7 odd control " : "R6 even control ", tag},
              int'(mem[2 + L/2]), int'(exp_w));
        bad_hits = 0;
        for (int a = 0; a < 1024; a++)
            if (hits[a] != ((a < words) ? 1 : 0)) bad_hits++;
        check(bad_hits == 0 && n_writes == words, {"R8 address coverage ", tag}, n_writes, words);
        check(n_done == 1 && seen_words == words, {"R9 done pulse ", tag}, seen_words, words);
        check(done_addr_bad == 0, {"R5 done with count write ", tag}, done_addr_bad, 0);
        check(ready_after_last == 0, {"R11 ready closed ", tag}, ready_after_last, 0);
        if (bubbles)
            check(bad_payload == 0 && mem[1] === 16'(L + 6), {"R10 bubbles harmless ", tag},
                  bad_payload, 0);
    endtask

    task automatic test_reset();
        rst = 1'b1; in_valid = 1'b1;
        repeat (3) @(negedge clk);
        check(wr_en == 1'b0 && done == 1'b0 && in_ready == 1'b0, "R1 during reset",
              {wr_en, done, in_ready}, 0);
        in_valid = 1'b0;
        rst = 1'b0;
        @(negedge clk);
        check(wr_en == 1'b0 && done == 1'b0 && in_ready == 1'b0, "R1 after reset",
              {wr_en, done, in_ready}, 0);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        #(1_500_000ns);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog expired actual=1 expected=0");
        finish_run();
    end

    initial begin
        test_reset();
        run_frame(1,    3, 1'b0, "single byte R4");
        run_frame(59,   5, 1'b0, "59 bytes R4");
        run_frame(60,   9, 1'b0, "60 bytes");
        run_frame(61,  11, 1'b0, "61 bytes R7");
        run_frame(64,  17, 1'b0, "64 bytes R6");
        run_frame(2,   21, 1'b1, "two bytes bubbles R10");
        run_frame(101, 23, 1'b1, "101 bytes bubbles R10");
        run_frame(1513, 29, 1'b0, "1513 bytes");
        run_frame(1514, 31, 1'b0, "1514 bytes R11 back-to-back");
        finish_run();
    end

endmodule